// File: doc/BRIEF.md
# Interrupt Response Sequencer

This block is the interrupt front end of an 8-bit processor with a 16-bit address space. It watches two request lines. One is a nonmaskable request, detected on its rising edge and held as pending. The other is a maskable request, sampled as a level. Requests are taken only when the instruction sequencer signals an instruction boundary and the block is idle. The block keeps the two interrupt-enable flags. The decoder drives three strobes, enable, disable and return-from-nonmaskable, and these update the flags while no sequence is running.

Once a request is accepted, the block saves the program counter on the stack as two byte writes on a simple memory port. The high byte goes first, one below the stack pointer, and the low byte goes two below it. The block then hands a new program counter and the decremented stack pointer to the core in a single load cycle.

There are two maskable modes.
- In fixed mode the handler lies at a constant restart address.
- In table mode the block latches a vector byte from the device during a one-cycle acknowledge strobe. It forms a table address from a page register and that byte, and fetches a two-byte handler pointer from the table.

Software can re-enable interrupts inside a handler, so a later request can nest.

Top module: `irqSequencer`

## Requirements
- R1: A rising edge on `nmiReq` sets a pending flag. At an instruction boundary while idle, a pending nonmaskable request is accepted whatever `iff1` holds, and its sequence ends with a load of `pcNew` = 0x0066.
- R2: A maskable request (`intReq` high) is accepted only at an instruction boundary while idle and with `iff1` = 1. The cycle after acceptance has `intAck` high for exactly one cycle. With `iff1` = 0 nothing starts.
- R3: Accepting a nonmaskable request first copies `iff1` into `iff2`, then clears `iff1`. Accepting a maskable request clears both flags.
- R4: While idle, `disInt` clears both flags, `enInt` sets both, and `retIntr` copies `iff2` into `iff1`, in that priority order. These strobes have no effect while `busy` is high.
- R5: The push follows acceptance directly, or follows the acknowledge cycle for a maskable request. It takes two consecutive write cycles: `pcIn[15:8]` to SP-1, then `pcIn[7:0]` to SP-2, with addresses wrapping modulo 2^16.
- R6: In fixed mode (`modeTable` = 0), the cycle after the low-byte write has `pcLoad` high, `pcNew` = 0x0038 and `spNew` = SP-2.
- R7: In table mode (`modeTable` = 1), the vector byte is taken from `busIn` during the acknowledge cycle with bit 0 forced to 0. After the push, two read cycles follow: one at {`pageReg`, vector} and one at that address plus 1. `busIn` is sampled in each read cycle, as the low byte and then the high byte. The next cycle loads `pcNew` = {high, low}.
- R8: A pending nonmaskable request wins over a maskable one at the same boundary. A rising edge during a running sequence stays pending until the next boundary after the sequence ends. A level held high does not trigger again.
- R9: `pcIn`, `spIn`, `pageReg` and `modeTable` are captured at acceptance. Changes to them while `busy` is high do not alter the running sequence.
- R10: After reset the block is idle, both flags are 0, nothing is pending, and `intAck`, `memReq`, `memWe` and `pcLoad` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nmiReq | input | 1 | Nonmaskable request, edge sensitive |
| intReq | input | 1 | Maskable request, level sensitive |
| insnBoundary | input | 1 | High in a cycle where an interrupt may be taken |
| modeTable | input | 1 | 0 = fixed restart, 1 = vector table |
| enInt | input | 1 | Set both enable flags |
| disInt | input | 1 | Clear both enable flags |
| retIntr | input | 1 | Restore iff1 from iff2 |
| pageReg | input | 8 | Upper byte of the vector table address |
| pcIn | input | 16 | Current program counter |
| spIn | input | 16 | Current stack pointer |
| busIn | input | 8 | Vector byte during acknowledge, read data during reads |
| intAck | output | 1 | One-cycle acknowledge of a maskable request |
| memReq | output | 1 | Memory access this cycle |
| memWe | output | 1 | The access is a write |
| memAddr | output | 16 | Access address |
| memWdata | output | 8 | Write data |
| pcLoad | output | 1 | Load new PC and SP this cycle |
| pcNew | output | 16 | Handler address |
| spNew | output | 16 | Stack pointer after the push |
| busy | output | 1 | A sequence is running |
| iff1 | output | 1 | Interrupt enable flag |
| iff2 | output | 1 | Saved copy of the enable flag |

## Verification
The bench targets these corner cases:
- **Stack pointer wrap.** The push starts at a stack pointer of 0x0001, so the two writes land at 0x0000 and 0xFFFF. A design with a truncated or sign-confused decrement puts the low byte at a wrong address.
- **Odd vector byte.** The device supplies an odd vector byte. A design that fails to force bit 0 low reads a misaligned handler pointer.
- **Coincident requests.** Both requests arrive together, and a fresh nonmaskable edge appears mid-sequence. A design that loses the pending flag, or that re-triggers on a held level, serves the wrong handler or an extra one.
- **Inputs changing while busy.** Enable strobes and the captured inputs change during a sequence. A design without capture, or one that honours flag strobes while busy, changes the pushed bytes, the handler address or the flag values.

// File: rtl/irqSeqPkg.sv
package irqSeqPkg;

  typedef enum logic [2:0] {
    S_IDLE, S_ACK, S_PUSHH, S_PUSHL, S_RDLO, S_RDHI, S_LOAD
  } seqState_t;

  typedef enum logic [1:0] {
    SVC_NMI, SVC_FIXED, SVC_TABLE
  } svcKind_t;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic     capture;
    logic     takeVec;
    logic     pushHi;
    logic     pushLo;
    logic     readLo;
    logic     readHi;
    logic     load;
    svcKind_t kind;
  } seqStrobe_t;

endpackage

// File: rtl/irqSeqCtrl.sv
module irqSeqCtrl
  import irqSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       nmiReq,
  input  logic       intReq,
  input  logic       insnBoundary,
  input  logic       modeTable,
  input  logic       enInt,
  input  logic       disInt,
  input  logic       retIntr,
  output seqStrobe_t strobe,
  output logic       intAck,
  output logic       memReq,
  output logic       memWe,
  output logic       pcLoad,
  output logic       busy,
  output logic       iff1,
  output logic       iff2
);

  seqState_t state, stateNext;
  svcKind_t  kindQ;
  logic      nmiPrev, nmiPend;
  logic      idle, takeNmi, takeInt;

  assign idle    = (state == S_IDLE);
  assign takeNmi = idle && insnBoundary && nmiPend;
  assign takeInt = idle && insnBoundary && !nmiPend && intReq && iff1;

  always_comb begin
    stateNext = state;
    case (state)
      S_IDLE:  if (takeNmi) stateNext = S_PUSHH;
               else if (takeInt) stateNext = S_ACK;
      S_ACK:   stateNext = S_PUSHH;
      S_PUSHH: stateNext = S_PUSHL;
      S_PUSHL: stateNext = (kindQ == SVC_TABLE) ? S_RDLO : S_LOAD;
      S_RDLO:  stateNext = S_RDHI;
      S_RDHI:  stateNext = S_LOAD;
      S_LOAD:  stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      kindQ   <= SVC_NMI;
      nmiPrev <= 1'b0;
      nmiPend <= 1'b0;
      iff1    <= 1'b0;
      iff2    <= 1'b0;
    end else begin
      state   <= stateNext;
      nmiPrev <= nmiReq;
      nmiPend <= (nmiPend && !takeNmi) || (nmiReq && !nmiPrev);
      if (takeNmi) begin
        kindQ <= SVC_NMI;
        iff2  <= iff1;
        iff1  <= 1'b0;
      end else if (takeInt) begin
        kindQ <= modeTable ? SVC_TABLE : SVC_FIXED;
        iff1  <= 1'b0;
        iff2  <= 1'b0;
      end else if (idle) begin
        if (disInt) begin
          iff1 <= 1'b0;
          iff2 <= 1'b0;
        end else if (enInt) begin
          iff1 <= 1'b1;
          iff2 <= 1'b1;
        end else if (retIntr) begin
          iff1 <= iff2;
        end
      end
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.capture = takeNmi || takeInt;
    strobe.takeVec = (state == S_ACK);
    strobe.pushHi  = (state == S_PUSHH);
    strobe.pushLo  = (state == S_PUSHL);
    strobe.readLo  = (state == S_RDLO);
    strobe.readHi  = (state == S_RDHI);
    strobe.load    = (state == S_LOAD);
    strobe.kind    = kindQ;
  end

  assign intAck = strobe.takeVec;
  assign memWe  = strobe.pushHi || strobe.pushLo;
  assign memReq = memWe || strobe.readLo || strobe.readHi;
  assign pcLoad = strobe.load;
  assign busy   = !idle;

endmodule

// File: rtl/irqSeqDpath.sv
module irqSeqDpath
  import irqSeqPkg::*;
#(
  parameter int              ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] NMI_VEC = 16'h0066,
  parameter logic [ADDR_W-1:0] FIX_VEC = 16'h0038
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic [ADDR_W/2-1:0] pageReg,
  input  logic [ADDR_W-1:0]   pcIn,
  input  logic [ADDR_W-1:0]   spIn,
  input  logic [ADDR_W/2-1:0] busIn,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [ADDR_W/2-1:0] memWdata,
  output logic [ADDR_W-1:0]   pcNew,
  output logic [ADDR_W-1:0]   spNew
);

  localparam int DATA_W = ADDR_W / 2;

  logic [ADDR_W-1:0] pcQ, spQ;
  logic [DATA_W-1:0] pageQ, vecQ, tblLo, tblHi;
  logic [ADDR_W-1:0] tblAddr, target;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ   <= '0;
      spQ   <= '0;
      pageQ <= '0;
      vecQ  <= '0;
      tblLo <= '0;
      tblHi <= '0;
    end else begin
      if (strobe.capture) begin
        pcQ   <= pcIn;
        spQ   <= spIn;
        pageQ <= pageReg;
      end
      // entries are two bytes, so the device byte is forced even
      if (strobe.takeVec) vecQ  <= {busIn[DATA_W-1:1], 1'b0};
      if (strobe.readLo)  tblLo <= busIn;
      if (strobe.readHi)  tblHi <= busIn;
    end
  end

  assign tblAddr = {pageQ, vecQ};

  always_comb begin
    memAddr  = '0;
    memWdata = '0;
    if (strobe.pushHi) begin
      memAddr  = spQ - ADDR_W'(1);
      memWdata = pcQ[ADDR_W-1:DATA_W];
    end else if (strobe.pushLo) begin
      memAddr  = spQ - ADDR_W'(2);
      memWdata = pcQ[DATA_W-1:0];
    end else if (strobe.readLo) begin
      memAddr = tblAddr;
    end else if (strobe.readHi) begin
      memAddr = {pageQ, vecQ[DATA_W-1:1], 1'b1};
    end
  end

  always_comb begin
    case (strobe.kind)
      SVC_NMI:   target = NMI_VEC;
      SVC_FIXED: target = FIX_VEC;
      default:   target = {tblHi, tblLo};
    endcase
  end

  assign pcNew = strobe.load ? target : '0;
  assign spNew = spQ - ADDR_W'(2);

endmodule

// File: rtl/irqSequencer.sv
module irqSequencer
  import irqSeqPkg::*;
#(
  parameter int                ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] NMI_VEC = 16'h0066,
  parameter logic [ADDR_W-1:0] FIX_VEC = 16'h0038
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                nmiReq,
  input  logic                intReq,
  input  logic                insnBoundary,
  input  logic                modeTable,
  input  logic                enInt,
  input  logic                disInt,
  input  logic                retIntr,
  input  logic [ADDR_W/2-1:0] pageReg,
  input  logic [ADDR_W-1:0]   pcIn,
  input  logic [ADDR_W-1:0]   spIn,
  input  logic [ADDR_W/2-1:0] busIn,
  output logic                intAck,
  output logic                memReq,
  output logic                memWe,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [ADDR_W/2-1:0] memWdata,
  output logic                pcLoad,
  output logic [ADDR_W-1:0]   pcNew,
  output logic [ADDR_W-1:0]   spNew,
  output logic                busy,
  output logic                iff1,
  output logic                iff2
);

  seqStrobe_t strobe;

  irqSeqCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .nmiReq(nmiReq), .intReq(intReq),
    .insnBoundary(insnBoundary), .modeTable(modeTable),
    .enInt(enInt), .disInt(disInt), .retIntr(retIntr),
    .strobe(strobe), .intAck(intAck), .memReq(memReq), .memWe(memWe),
    .pcLoad(pcLoad), .busy(busy), .iff1(iff1), .iff2(iff2)
  );

  irqSeqDpath #(.ADDR_W(ADDR_W), .NMI_VEC(NMI_VEC), .FIX_VEC(FIX_VEC)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pageReg(pageReg),
    .pcIn(pcIn), .spIn(spIn), .busIn(busIn), .memAddr(memAddr),
    .memWdata(memWdata), .pcNew(pcNew), .spNew(spNew)
  );

endmodule

// File: rtl/irqSequencerChk.sv
module irqSequencerChk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              intAck,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              pcLoad,
  input logic [ADDR_W-1:0] spNew,
  input logic              busy,
  input logic              iff1,
  input logic              iff2
);

  localparam logic [ADDR_W-1:0] ONE = 1;

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    intAck |=> !intAck); // R2
  AST_ACK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && intAck) |-> $past(iff1)); // R2
  AST_IFF_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !iff1); // R3
  AST_NMI_COPY: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && !intAck) |-> (iff2 == $past(iff1))); // R3
  AST_PUSH_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && !$past(memWe)) |=> (memWe && memAddr == $past(memAddr) - ONE)); // R5
  AST_LOAD_SP: assert property (@(posedge clk) disable iff (!rstN)
    (pcLoad && $past(memWe)) |-> (spNew == $past(memAddr))); // R6
  AST_TBL_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe && $past(memWe)) |-> !memAddr[0]); // R7
  AST_TBL_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe && $past(memReq) && !$past(memWe))
      |-> (memAddr == ($past(memAddr) | ONE))); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(memReq || pcLoad || intAck)); // R10

endmodule

bind irqSequencer irqSequencerChk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .intAck(intAck), .memReq(memReq), .memWe(memWe),
  .memAddr(memAddr), .pcLoad(pcLoad), .spNew(spNew), .busy(busy),
  .iff1(iff1), .iff2(iff2)
);

// File: tb/irqSequencer_tb.sv
module irqSequencer_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        nmiReq = 1'b0, intReq = 1'b0, bnd = 1'b0, modeTable = 1'b0;
  logic        enInt = 1'b0, disInt = 1'b0, retIntr = 1'b0;
  logic [7:0]  pageReg = 8'h00, vecDrive = 8'h00;
  logic [15:0] pcIn = 16'h0000, spIn = 16'h0000;
  logic [7:0]  busIn;
  logic        intAck, memReq, memWe, pcLoad, busy, iff1, iff2;
  logic [15:0] memAddr, pcNew, spNew;
  logic [7:0]  memWdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  irqSequencer u_dut (
    .clk(clk), .rstN(rstN), .nmiReq(nmiReq), .intReq(intReq),
    .insnBoundary(bnd), .modeTable(modeTable), .enInt(enInt),
    .disInt(disInt), .retIntr(retIntr), .pageReg(pageReg), .pcIn(pcIn),
    .spIn(spIn), .busIn(busIn), .intAck(intAck), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .pcLoad(pcLoad),
    .pcNew(pcNew), .spNew(spNew), .busy(busy), .iff1(iff1), .iff2(iff2)
  );

  // bench memory: every byte is a fixed function of its address
  function automatic logic [7:0] memByte(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  assign busIn = intAck ? vecDrive : memByte(memAddr);

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  typedef struct packed {
    bit        ack, rq, we, ld;
    bit [1:0]  kind;  // 0 nonmaskable, 1 fixed, 2 table
    bit [15:0] addr;
    bit [7:0]  wdata;
    bit [15:0] pc, sp;
  } exp_t;

  exp_t q[$];
  bit   mIff1, mIff2, mPend, mPrev;

  function automatic string tagOf(bit [1:0] k);
    if (k == 2'd0) return "R1";
    if (k == 2'd1) return "R6";
    return "R7"; // table handler, also guards R9 capture
  endfunction

  task automatic buildSeq(bit [1:0] k);
    exp_t e;
    bit [15:0] t;
    bit [15:0] tgt;
    if (k != 2'd0) begin
      e = '0; e.ack = 1; e.kind = k; q.push_back(e);
    end
    e = '0; e.rq = 1; e.we = 1; e.kind = k;
    e.addr = spIn - 16'd1; e.wdata = pcIn[15:8]; q.push_back(e);
    e.addr = spIn - 16'd2; e.wdata = pcIn[7:0];  q.push_back(e);
    tgt = (k == 2'd0) ? 16'h0066 : 16'h0038;
    if (k == 2'd2) begin
      t = {pageReg, vecDrive & 8'hFE};
      e = '0; e.rq = 1; e.kind = k; e.addr = t; q.push_back(e);
      e.addr = t | 16'd1; q.push_back(e);
      tgt = {memByte(t | 16'd1), memByte(t)};
    end
    e = '0; e.ld = 1; e.kind = k; e.pc = tgt; e.sp = spIn - 16'd2;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rstN) begin
      q.delete();
      mIff1 = 0; mIff2 = 0; mPend = 0; mPrev = 0;
    end else begin
      bit wasIdle;
      bit takeN, takeI;
      exp_t e;
      string tg;
      wasIdle = (q.size() == 0);
      e = wasIdle ? '0 : q[0];
      tg = wasIdle ? "R2" : tagOf(e.kind);
      chk(tg, "busy", busy, !wasIdle);
      chk("R2", "intAck", intAck, e.ack);
      chk("R5", "memReq", memReq, e.rq);
      chk("R5", "memWe", memWe, e.we);
      if (e.rq) chk(e.we ? "R5" : "R7", "memAddr", memAddr, e.addr);
      if (e.we) chk("R5", "memWdata", memWdata, e.wdata);
      chk(tg, "pcLoad", pcLoad, e.ld);
      if (e.ld) begin
        chk(tg, "pcNew", pcNew, e.pc);
        chk("R6", "spNew", spNew, e.sp);
      end
      chk("R3", "iff1", iff1, mIff1);
      chk("R3", "iff2", iff2, mIff2);
      if (!wasIdle) void'(q.pop_front());
      takeN = wasIdle && bnd && mPend;
      takeI = wasIdle && bnd && !mPend && intReq && mIff1;
      if (takeN) begin
        buildSeq(2'd0);
        mIff2 = mIff1; mIff1 = 0;
      end else if (takeI) begin
        buildSeq(modeTable ? 2'd2 : 2'd1);
        mIff1 = 0; mIff2 = 0;
      end else if (wasIdle) begin
        if (disInt) begin mIff1 = 0; mIff2 = 0; end
        else if (enInt) begin mIff1 = 1; mIff2 = 1; end
        else if (retIntr) mIff1 = mIff2;
      end
      mPend = (mPend && !takeN) || (nmiReq && !mPrev);
      mPrev = nmiReq;
    end
    if (cyc > 20000) begin
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulseBnd();
    bnd = 1; step(1); bnd = 0;
  endtask

  task automatic pulseEn();
    enInt = 1; step(1); enInt = 0;
  endtask

  task automatic waitIdle();
    for (int g = 0; g < 40 && busy; g++) step(1);
    step(1);
  endtask

  initial begin
    step(3);
    rstN = 1;
    step(1);
    // R10: quiet after reset
    chk("R10", "busy", busy, 0);
    chk("R10", "iff1", iff1, 0);
    chk("R10", "memReq", memReq, 0);

    // R2: maskable request refused while disabled
    intReq = 1;
    pulseBnd(); pulseBnd(); step(1);
    chk("R2", "busy while disabled", busy, 0);
    chk("R2", "intAck while disabled", intAck, 0);
    intReq = 0;

    // R6: fixed mode
    pulseEn();
    pcIn = 16'h1234; spIn = 16'h8000; modeTable = 0; intReq = 1;
    pulseBnd(); intReq = 0;
    waitIdle();
    chk("R3", "iff1 after fixed", iff1, 0);

    // R7 with odd vector and wrapping stack; R9 and R4 inputs changed while busy
    pulseEn();
    modeTable = 1; pageReg = 8'h12; vecDrive = 8'h35;
    pcIn = 16'hABCD; spIn = 16'h0001; intReq = 1;
    pulseBnd(); intReq = 0;
    pcIn = 16'h0000; pageReg = 8'hFF; modeTable = 0; spIn = 16'h5555;
    enInt = 1; step(1); enInt = 0;
    waitIdle();
    chk("R4", "iff1 after ignored enable", iff1, 0);

    // R1: nonmaskable with flags clear
    pcIn = 16'h4321; spIn = 16'h2000;
    nmiReq = 1; step(1); pulseBnd(); waitIdle(); nmiReq = 0; step(1);
    chk("R1", "iff2 copy of clear flag", iff2, 0);

    // R3 / R4: nonmaskable with flags set, then restore
    pulseEn();
    nmiReq = 1; step(1); pulseBnd(); waitIdle();
    chk("R3", "iff1 cleared", iff1, 0);
    chk("R3", "iff2 saved", iff2, 1);
    retIntr = 1; step(1); retIntr = 0; step(1);
    chk("R4", "iff1 restored", iff1, 1);
    // R8: held level must not trigger again
    pulseBnd(); step(1);
    chk("R8", "no retrigger on level", busy, 0);
    nmiReq = 0; step(1);

    // R8: priority and edge during a sequence
    pcIn = 16'h0F0F; spIn = 16'hC000; modeTable = 1; pageReg = 8'h40; vecDrive = 8'h08;
    intReq = 1; nmiReq = 1; step(1);
    pulseBnd();
    chk("R8", "nonmaskable first, no ack", intAck, 0);
    nmiReq = 0; step(1); nmiReq = 1; step(1); nmiReq = 0;
    waitIdle();
    pulseEn();
    pulseBnd(); waitIdle();   // pending nonmaskable served before intReq
    pulseEn();
    pulseBnd(); intReq = 0; waitIdle();  // now the table request

    // R4: disable wins
    pulseEn();
    disInt = 1; step(1); disInt = 0;
    intReq = 1; pulseBnd(); step(1);
    chk("R4", "busy after disable", busy, 0);
    intReq = 0;
    step(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule